// File: doc/BRIEF.md
# Two-Input Three-Output Audio Mix Matrix

This block sits after a 2x oversampling stage and turns a stereo pair of sample streams (left and right) into three output channels. Each output is a weighted sum of the two inputs. Every output has its own pair of signed fractional gains, one for the left input and one for the right, so there are six gains in total. With the reset gains, output 1 carries left, output 2 carries right, and output 3 carries a half-level mono sum. That third channel is typically used to feed a low-frequency output in a 2.1 arrangement.

Samples enter with a one-cycle valid strobe, at most one per clock, at twice the audio rate. The results leave with their own valid strobe exactly two clocks later. The stream has no ready signal, so it has no back-pressure. The source may strobe on any cycle, back-to-back included. The sink must take every output strobe in the cycle it appears, because nothing is held for it. Between strobes the outputs keep the last result.

Gains load through a simple register write port: a write enable, a 3-bit slot select and 24-bit data. A sample uses the gain set that is in the registers in its own strobe cycle. All three outputs of one sample therefore come from one coherent set.

Top module: `mixmat_top`

## Requirements
- R1: Each output n (n = 1, 2, 3) equals (L·Gn_left + R·Gn_right + 2^22) >> 23, with an arithmetic shift. L and R are 24-bit two's-complement samples. The gains are 24-bit two's-complement fractions, so 0x7FFFFF is just below +1.0 and 0x800000 is −1.0.
- R2: A result above 0x7FFFFF is clamped to 0x7FFFFF (+8388607). A result below −8388608 is clamped to 0x800000. It never wraps.
- R3: After reset the gains are: output 1 left 0x7FFFFF, right 0; output 2 left 0, right 0x7FFFFF; output 3 left 0x400000, right 0x400000.
- R4: out_valid is high exactly two clock cycles after each cycle in which in_valid is high, and at no other time.
- R5: A gain write sampled in the same clock as an input strobe does not affect that sample. It affects every sample strobed in a later cycle.
- R6: The slot select coef_sel picks the gain as follows: 0 is output 1 left, 1 is output 1 right, 2 is output 2 left, 3 is output 2 right, 4 is output 3 left and 5 is output 3 right. A write with select 6 or 7 changes no gain.
- R7: While rst_n is low, and for the first two cycles after it rises, out_valid is 0. During reset all outputs are 0.
- R8: The output channels change only in a cycle in which out_valid is high. Otherwise they hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| coef_we | input | 1 | Gain write enable |
| coef_sel | input | 3 | Gain slot select |
| coef_wdata | input | 24 | Gain value, signed fraction |
| out_valid | output | 1 | Output sample strobe |
| out_ch1 | output | 24 | Output channel 1 |
| out_ch2 | output | 24 | Output channel 2 |
| out_ch3 | output | 24 | Output channel 3 |

## Verification
The bound checker watches five things on every cycle: the two-cycle strobe delay, the quiet output valid just after reset, that outputs hold between strobes, that the gain registers stay unchanged unless a write with a legal select arrived, and the gain values in the first cycle out of reset. The arithmetic cannot be shown by those checks: rounding, clamping at both rails, and which gain set a given sample used. Only the bench's scenarios show them, by comparing every cycle against a behavioural model. The same applies to a write landing in the very cycle of a strobe, and to writes with selects 6 and 7 leaving the outputs untouched.

// File: rtl/mixmat_pkg.sv
package mixmat_pkg;
  localparam int NUM_OUT  = 3;
  localparam int NUM_IN   = 2;
  localparam int NUM_COEF = NUM_OUT * NUM_IN;
  localparam int SEL_W    = $clog2(NUM_COEF);

  // Reset gain for slot idx (slot = 2*output + input, input 0 = left)
  function automatic logic [63:0] default_gain(input int idx, input int cw);
    logic [63:0] unity;
    logic [63:0] half;
    unity = (64'd1 << (cw - 1)) - 64'd1;
    half  = 64'd1 << (cw - 2);
    case (idx)
      0:       return unity;
      3:       return unity;
      4:       return half;
      5:       return half;
      default: return 64'd0;
    endcase
  endfunction
endpackage

// File: rtl/mixmat_coef_bank.sv
module mixmat_coef_bank
  import mixmat_pkg::*;
#(
  parameter int COEF_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [SEL_W-1:0]           sel,
  input  logic [COEF_W-1:0]          wdata,
  output logic [NUM_COEF*COEF_W-1:0] coef_flat
);
  for (genvar i = 0; i < NUM_COEF; i++) begin : g_slot
    localparam logic [63:0] DEF = default_gain(i, COEF_W);
    logic [COEF_W-1:0] gain_q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        gain_q <= DEF[COEF_W-1:0];
      else if (we && (sel == SEL_W'(i)))
        gain_q <= wdata;
    end

    assign coef_flat[i*COEF_W +: COEF_W] = gain_q;
  end
endmodule

// File: rtl/mixmat_vpipe.sv
module mixmat_vpipe #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vin,
  output logic [DEPTH-1:0] stage
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      stage <= '0;
    else
      stage <= DEPTH'({stage, vin});
  end
endmodule

// File: rtl/mixmat_lane.sv
module mixmat_lane #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     mid_valid,
  input  logic signed [DATA_W-1:0] left,
  input  logic signed [DATA_W-1:0] right,
  input  logic signed [COEF_W-1:0] c_left,
  input  logic signed [COEF_W-1:0] c_right,
  output logic signed [DATA_W-1:0] mixed
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + 1;
  localparam int FRAC   = COEF_W - 1;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) << (DATA_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) << (DATA_W - 1));

  logic signed [PROD_W-1:0] prod_l, prod_r;
  logic signed [ACC_W-1:0]  acc, rnd, shf, clamped;

  // Stage 1: both products, gains taken in the strobe cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_l <= '0;
      prod_r <= '0;
    end else if (in_valid) begin
      prod_l <= PROD_W'(left)  * PROD_W'(c_left);
      prod_r <= PROD_W'(right) * PROD_W'(c_right);
    end
  end

  // Sum, round half up, rescale, clamp
  always_comb begin
    acc = ACC_W'(prod_l) + ACC_W'(prod_r);
    rnd = acc + HALF_LSB;
    shf = rnd >>> FRAC;
    if (shf > MAXV)
      clamped = MAXV;
    else if (shf < MINV)
      clamped = MINV;
    else
      clamped = shf;
  end

  // Stage 2: result register, held between strobes
  always_ff @(posedge clk) begin
    if (!rst_n)
      mixed <= '0;
    else if (mid_valid)
      mixed <= clamped[DATA_W-1:0];
  end
endmodule

// File: rtl/mixmat_top.sv
module mixmat_top
  import mixmat_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic              coef_we,
  input  logic [2:0]        coef_sel,
  input  logic [COEF_W-1:0] coef_wdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_ch1,
  output logic [DATA_W-1:0] out_ch2,
  output logic [DATA_W-1:0] out_ch3
);
  localparam int LAT = 2;

  logic [NUM_COEF*COEF_W-1:0] coef_flat;
  logic [LAT-1:0]             vstage;
  logic [DATA_W-1:0]          lane_out [NUM_OUT];

  mixmat_coef_bank #(.COEF_W(COEF_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (coef_we),
    .sel       (coef_sel[SEL_W-1:0]),
    .wdata     (coef_wdata),
    .coef_flat (coef_flat)
  );

  mixmat_vpipe #(.DEPTH(LAT)) u_vpipe (
    .clk   (clk),
    .rst_n (rst_n),
    .vin   (in_valid),
    .stage (vstage)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    mixmat_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .mid_valid (vstage[0]),
      .left      (in_left),
      .right     (in_right),
      .c_left    (coef_flat[(2*g)*COEF_W +: COEF_W]),
      .c_right   (coef_flat[(2*g+1)*COEF_W +: COEF_W]),
      .mixed     (lane_out[g])
    );
  end

  assign out_valid = vstage[LAT-1];
  assign out_ch1   = lane_out[0];
  assign out_ch2   = lane_out[1];
  assign out_ch3   = lane_out[2];
endmodule

// File: rtl/mixmat_chk.sv
module mixmat_chk
  import mixmat_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       coef_we,
  input logic [2:0]                 coef_sel,
  input logic                       out_valid,
  input logic [DATA_W-1:0]          out_ch1,
  input logic [DATA_W-1:0]          out_ch2,
  input logic [DATA_W-1:0]          out_ch3,
  input logic [NUM_COEF*COEF_W-1:0] coef_flat
);
  logic [1:0]                 age;
  logic [NUM_COEF*COEF_W-1:0] def_flat;

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_def
    localparam logic [63:0] DEF = default_gain(i, COEF_W);
    assign def_flat[i*COEF_W +: COEF_W] = DEF[COEF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      age <= '0;
    else if (age != 2'd3)
      age <= age + 2'd1;
  end

  AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R4

  AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
    (age < 2'd2) |-> !out_valid); // R7

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !out_valid) |-> $stable({out_ch1, out_ch2, out_ch3})); // R8

  AST_GAIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !($past(coef_we) && ($past(coef_sel) < 3'(NUM_COEF))))
      |-> $stable(coef_flat)); // R6

  AST_GAIN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (coef_flat == def_flat)); // R3
endmodule

bind mixmat_top mixmat_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .coef_we   (coef_we),
  .coef_sel  (coef_sel),
  .out_valid (out_valid),
  .out_ch1   (out_ch1),
  .out_ch2   (out_ch2),
  .out_ch3   (out_ch3),
  .coef_flat (coef_flat)
);

// File: tb/mixmat_top_tb_top.sv
module mixmat_top_tb_top;
  localparam int DW = 24;
  localparam int CW = 24;
  localparam longint SMAX = (longint'(1) << (DW - 1)) - 1;
  localparam longint SMIN = -(longint'(1) << (DW - 1));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_left = '0;
  logic [DW-1:0] in_right = '0;
  logic          coef_we = 1'b0;
  logic [2:0]    coef_sel = '0;
  logic [CW-1:0] coef_wdata = '0;
  logic          out_valid;
  logic [DW-1:0] out_ch1, out_ch2, out_ch3;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  // behavioural model state
  longint gm [6];
  bit     mv1, mov;
  longint md1 [3];
  longint mo [3];

  always #5 clk = ~clk;

  mixmat_top #(.DATA_W(DW), .COEF_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_wdata(coef_wdata), .out_valid(out_valid), .out_ch1(out_ch1),
    .out_ch2(out_ch2), .out_ch3(out_ch3)
  );

  function automatic longint mix(longint l, longint r, longint gl, longint gr);
    longint s;
    s = l * gl + r * gr + (longint'(1) <<< (CW - 2));
    s = s >>> (CW - 1);
    if (s > SMAX) s = SMAX;
    if (s < SMIN) s = SMIN;
    return s;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    gm[0] = SMAX; gm[1] = 0; gm[2] = 0; gm[3] = SMAX;
    gm[4] = longint'(1) << (CW - 2); gm[5] = longint'(1) << (CW - 2);
    mv1 = 0; mov = 0;
    for (int k = 0; k < 3; k++) begin md1[k] = 0; mo[k] = 0; end
  endtask

  task automatic step(bit v, longint l, longint r, bit we, int sel, longint wd, string tag);
    longint act [3];
    @(negedge clk);
    act[0] = longint'($signed(out_ch1));
    act[1] = longint'($signed(out_ch2));
    act[2] = longint'($signed(out_ch3));
    check(out_valid == mov, "R4", "out_valid", longint'(out_valid), longint'(mov));
    for (int k = 0; k < 3; k++)
      check(act[k] == mo[k], mov ? tag : "R8", $sformatf("out_ch%0d", k + 1), act[k], mo[k]);
    in_valid   = v;
    in_left    = DW'(l);
    in_right   = DW'(r);
    coef_we    = we;
    coef_sel   = 3'(sel);
    coef_wdata = CW'(wd);
    if (mv1) for (int k = 0; k < 3; k++) mo[k] = md1[k];
    mov = mv1;
    mv1 = v;
    if (v) for (int k = 0; k < 3; k++) md1[k] = mix(l, r, gm[2*k], gm[2*k+1]);
    if (we && sel < 6) gm[sel] = wd;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  function automatic longint rnd_s();
    return longint'($signed(DW'($urandom())));
  endfunction

  initial begin
    model_reset();
    // R7: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", longint'(out_valid), 0);
    check({out_ch1, out_ch2, out_ch3} == '0, "R7", "outputs in reset",
          longint'($signed(out_ch1)), 0);
    rst_n = 1'b1;
    idle(2, "R7");

    // R3: reset gains, left/right pass and half mono sum
    step(1, 1000, -3000, 0, 0, 0, "R3");
    step(1, SMAX, SMIN, 0, 0, 0, "R3");
    for (int i = 0; i < 20; i++) step(1, rnd_s(), rnd_s(), 0, 0, 0, "R3");
    idle(3, "R3");

    // R1: programmed gains, mixed strobe patterns
    step(0, 0, 0, 1, 0, 24'sh200000, "R1");
    step(0, 0, 0, 1, 1, -(longint'(1) << 22), "R1");
    step(0, 0, 0, 1, 2, -12345, "R1");
    step(0, 0, 0, 1, 3, 3000000, "R1");
    step(0, 0, 0, 1, 4, -(longint'(1) << 23), "R1");
    step(0, 0, 0, 1, 5, 1, "R1");
    for (int i = 0; i < 60; i++) step(($urandom() % 3) != 0, rnd_s(), rnd_s(), 0, 0, 0, "R1");
    step(1, 3, -5, 0, 0, 0, "R1");
    step(1, -1, -1, 0, 0, 0, "R1");
    idle(3, "R1");

    // R2: clamping at both rails
    step(0, 0, 0, 1, 0, SMAX, "R2");
    step(0, 0, 0, 1, 1, SMAX, "R2");
    step(0, 0, 0, 1, 2, SMIN, "R2");
    step(0, 0, 0, 1, 3, SMIN, "R2");
    step(0, 0, 0, 1, 4, SMIN, "R2");
    step(0, 0, 0, 1, 5, 0, "R2");
    step(1, SMAX, SMAX, 0, 0, 0, "R2");
    step(1, SMIN, SMIN, 0, 0, 0, "R2");
    step(1, SMIN, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    step(1, SMAX, SMIN, 0, 0, 0, "R2");
    idle(3, "R2");

    // R5: write in the strobe cycle applies from the next sample only
    step(1, 400000, 400000, 1, 0, 24'sh100000, "R5");
    step(1, 400000, 400000, 1, 5, 24'sh300000, "R5");
    step(1, 400000, 400000, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 2, 24'sh080000, "R5");
    step(1, -700000, 250000, 0, 0, 0, "R5");
    for (int i = 0; i < 20; i++)
      step(1, rnd_s(), rnd_s(), ($urandom() % 2) == 1, $urandom() % 6, rnd_s(), "R5");
    idle(3, "R5");

    // R6: selects 6 and 7 leave every gain untouched
    step(0, 0, 0, 1, 6, SMAX, "R6");
    step(1, 123456, -654321, 1, 7, SMIN, "R6");
    step(1, SMAX, 77, 1, 6, 0, "R6");
    for (int i = 0; i < 10; i++) step(1, rnd_s(), rnd_s(), 1, 6 + ($urandom() % 2), rnd_s(), "R6");
    idle(3, "R6");

    // R4 / R8: isolated pulses with long gaps
    for (int i = 0; i < 8; i++) begin
      step(1, rnd_s(), rnd_s(), 0, 0, 0, "R4");
      idle(1 + i % 4, "R8");
    end
    idle(3, "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule